// File: doc/BRIEF.md
# Dual Interval/Toggle Timer

Two free-running down-counters share one clock and one small register bus. Each counter reloads itself from its own data register every time it expires. In interval mode the channel output is a single-cycle high pulse per expiry, so its rate is the clock rate divided by the reload count. In toggle mode the output flips on each expiry and starts from a level chosen by software, so its rate is the clock rate divided by twice the reload count. Every expiry also raises a one-cycle interrupt request, whatever the mode.

Software sets the reload counts first. It then writes the packed mode word, which holds three bits per channel: run, output style and starting level. Clearing a channel's run bit freezes that channel. Setting the bit again restarts the channel from a fresh reload.

Top module: `twin_timer`

## Requirements
- R1: Register map on `bus_addr`: 0 is the mode word, 1 is the channel 0 reload count, 2 is the channel 1 reload count. A write is stored at the clock edge where `bus_wr` is 1. `bus_rdata` shows the addressed register combinationally. Mode bits 6 and above read as 0 and have no effect. Address 3 reads as 0, and a write to it changes nothing.
- R2: Channel k uses mode bit 3k as run (1 = run), bit 3k+1 as style (0 = interval, 1 = toggle) and bit 3k+2 as the toggle starting level.
- R3: On the first clock edge where a channel's run bit reads 1 after reading 0, the counter loads the reload count and the toggle level takes the starting level. With reload count N, the first interrupt is visible in the (N+1)th cycle after the edge that stored the run bit.
- R4: The counter reloads itself at each expiry, giving one expiry every N cycles. A reload count of 0 or 1 acts as 1, so the channel expires every cycle.
- R5: In interval mode `tmr_out[k]` is high exactly in the cycles where `tmr_irq[k]` is high, and low otherwise.
- R6: In toggle mode `tmr_out[k]` inverts in the cycle after each expiry, giving a full output period of 2N cycles.
- R7: `tmr_irq[k]` is high for exactly one cycle per expiry in both modes.
- R8: While a channel's run bit is 0 it raises no interrupt and its toggle level holds. Setting the bit again restarts the channel as in R3.
- R9: A change to a reload count takes effect at the next reload. If the write lands on the same edge as a reload, that reload still uses the old count.
- R10: Both channels run independently at the same time with different counts and modes.
- R11: After reset all registers read 0 and both outputs and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| tmr_out | output | 2 | Per-channel pulse or toggle output |
| tmr_irq | output | 2 | Per-channel one-cycle expiry interrupt |

## Verification
A software write to a reload count and the counter's own reload can fall on the same clock edge. The bench times such a write to the edge on which a running channel expires. It then measures the spacing of the following interrupts: the next gap must still be the old count, and only the gap after it may be the new one. Random trials run both channels at once in mixed modes. They compare every output cycle against a model built from the reload rule.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // one channel's slice of the mode word; enable is the low bit
   typedef struct packed {
      logic init_lvl;
      logic toggle;
      logic enable;
   } chan_cfg_t;

   localparam int CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int NUM_TMR = 2,
   parameter int CNT_W   = 32,
   parameter int ADDR_W  = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_wr,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [CNT_W-1:0]           bus_wdata,
   output logic [CNT_W-1:0]           bus_rdata,
   output chan_cfg_t [NUM_TMR-1:0]    cfg,
   output logic [NUM_TMR*CNT_W-1:0]   reload_flat
);
   localparam int MODE_W = NUM_TMR * CFG_W;

   if (MODE_W > CNT_W) begin : g_bad_mode
      $error("mode word wider than bus");
   end
   if (NUM_TMR + 1 > (1 << ADDR_W)) begin : g_bad_addr
      $error("address too narrow for register count");
   end

   logic [MODE_W-1:0] mode_q;
   logic [CNT_W-1:0]  data_q [NUM_TMR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (bus_wr && bus_addr == '0) begin
         mode_q <= bus_wdata[MODE_W-1:0];
      end
   end

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_data
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_q[i] <= '0;
         end else if (bus_wr && bus_addr == ADDR_W'(i + 1)) begin
            data_q[i] <= bus_wdata;
         end
      end
      assign reload_flat[i*CNT_W +: CNT_W] = data_q[i];
      assign cfg[i] = mode_q[i*CFG_W +: CFG_W];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == '0) begin
         bus_rdata = CNT_W'(mode_q);
      end
      for (int i = 0; i < NUM_TMR; i++) begin
         if (bus_addr == ADDR_W'(i + 1)) begin
            bus_rdata = data_q[i];
         end
      end
   end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  chan_cfg_t        cfg,
   input  logic [CNT_W-1:0] reload,
   output logic             tout,
   output logic             irq
);
   if (CNT_W < 2) begin : g_bad_width
      $error("counter width must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload_eff;
   logic             run_q;
   logic             lvl_q;
   logic             irq_q;
   logic             start;
   logic             expire;

   assign reload_eff = (reload > CNT_W'(1)) ? reload : CNT_W'(1);
   assign start      = cfg.enable && !run_q;
   assign expire     = cfg.enable && run_q && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
         lvl_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         run_q <= cfg.enable;
         irq_q <= expire;
         if (start) begin
            cnt_q <= reload_eff;
            lvl_q <= cfg.init_lvl;
         end else if (cfg.enable) begin
            cnt_q <= expire ? reload_eff : cnt_q - CNT_W'(1);
            if (expire && cfg.toggle) begin
               lvl_q <= ~lvl_q;
            end
         end
      end
   end

   assign tout = cfg.toggle ? lvl_q : irq_q;
   assign irq  = irq_q;

   // R4: a running counter never sits at zero
   a_r4_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> cnt_q != '0);
   // R7: an interrupt only follows a cycle in which the channel was running
   a_r7_irq_from_run: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> ($past(run_q) && $past(cfg.enable)));
   // R3: a start edge leaves the toggle level at the programmed start value
   a_r3_start_level: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.enable && !run_q) |=> lvl_q == $past(cfg.init_lvl));
   // R8: a stopped channel stays silent
   a_r8_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.enable |=> !irq_q);
endmodule

// File: rtl/twin_timer.sv
module twin_timer
   import tmr_pkg::*;
#(
   parameter int NUM_TMR = 2,
   parameter int CNT_W   = 32,
   parameter int ADDR_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [CNT_W-1:0]   bus_wdata,
   output logic [CNT_W-1:0]   bus_rdata,
   output logic [NUM_TMR-1:0] tmr_out,
   output logic [NUM_TMR-1:0] tmr_irq
);
   if (NUM_TMR < 1) begin : g_bad_count
      $error("at least one channel required");
   end

   chan_cfg_t [NUM_TMR-1:0]  cfg;
   logic [NUM_TMR*CNT_W-1:0] reload_flat;

   tmr_regs #(
      .NUM_TMR (NUM_TMR),
      .CNT_W   (CNT_W),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .cfg         (cfg),
      .reload_flat (reload_flat)
   );

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_chan
      tmr_channel #(
         .CNT_W (CNT_W)
      ) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .cfg    (cfg[i]),
         .reload (reload_flat[i*CNT_W +: CNT_W]),
         .tout   (tmr_out[i]),
         .irq    (tmr_irq[i])
      );

      // R5: in interval mode the output pin mirrors the interrupt
      a_r5_pulse_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
         !cfg[i].toggle |-> tmr_out[i] == tmr_irq[i]);
   end
endmodule

// File: tb/sim_twin_timer.sv
module sim_twin_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  tmr_out;
   logic [1:0]  tmr_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   twin_timer u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tmr_out   (tmr_out),
      .tmr_irq   (tmr_irq)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // called at a negedge; returns at the next negedge
   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      bus_wr = 1'b1;
      bus_addr = a;
      bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic int eff(input int unsigned d);
      return (d < 2) ? 1 : int'(d);
   endfunction

   // k counts negedges after the edge that stored the run bit
   function automatic bit exp_irq(input int k, input int p);
      return (k >= 2) && (((k - 1) % p) == 0);
   endfunction

   function automatic bit exp_out(input int k, input int p, input bit tog, input bit lvl);
      if (!tog) return exp_irq(k, p);
      return lvl ^ bit'(((k - 1) / p) % 2);
   endfunction

   initial begin
      int wd = 0;
      forever begin
         @(posedge clk);
         wd++;
         if (wd > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            finish_run();
         end
      end
   end

   initial begin
      logic [31:0] rd;
      int gap;
      bit held;
      void'($urandom(32'd20240611));
      idle(2);
      // R11: reset state
      for (int a = 0; a < 4; a++) begin
         bus_read(2'(a), rd);
         chk(rd == 0, "R11 register after reset", rd, 0);
      end
      chk(tmr_out == 0 && tmr_irq == 0, "R11 outputs after reset", {tmr_out, tmr_irq}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: readback, reserved mode bits, unused address
      bus_write(2'd1, 32'h0000_0007);
      bus_write(2'd2, 32'hA5A5_0009);
      bus_write(2'd0, 32'hFFFF_FFC0);
      bus_write(2'd3, 32'h1234_5678);
      bus_read(2'd0, rd);
      chk(rd == 0, "R1 reserved mode bits read zero", rd, 0);
      bus_read(2'd1, rd);
      chk(rd == 32'h7, "R1 channel 0 count readback", rd, 7);
      bus_read(2'd2, rd);
      chk(rd == 32'hA5A5_0009, "R1 channel 1 count readback", rd, 32'hA5A5_0009);
      bus_read(2'd3, rd);
      chk(rd == 0, "R1 unused address reads zero", rd, 0);
      held = 1'b1;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (tmr_irq != 0 || tmr_out != 0) held = 1'b0;
      end
      chk(held, "R1 reserved bits start no channel", {tmr_out, tmr_irq}, 0);

      // R3 R4: data 0 expires every cycle; first interrupt at k=2
      bus_write(2'd1, 32'd0);
      bus_write(2'd0, 32'h01);
      chk(tmr_irq[0] == 1'b0, "R3 no interrupt on store edge", tmr_irq[0], 0);
      @(negedge clk);
      chk(tmr_irq[0] == 1'b0, "R3 no interrupt on load edge", tmr_irq[0], 0);
      held = 1'b1;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (!tmr_irq[0]) held = 1'b0;
      end
      chk(held, "R4 count 0 expires every cycle", 0, 1);

      // R2 R3 R4 R5 R6 R7 R10: random mixed trials on both channels
      for (int t = 0; t < 24; t++) begin
         int unsigned d0 = $urandom_range(12, 0);
         int unsigned d1 = $urandom_range(12, 0);
         bit t0 = 1'($urandom_range(1, 0));
         bit t1 = 1'($urandom_range(1, 0));
         bit l0 = 1'($urandom_range(1, 0));
         bit l1 = 1'($urandom_range(1, 0));
         int bad0 = -1;
         int bad1 = -1;
         bus_write(2'd0, 32'd0);
         idle(3);
         bus_write(2'd1, d0);
         bus_write(2'd2, d1);
         bus_write(2'd0, {26'd0, l1, t1, 1'b1, l0, t0, 1'b1});
         for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (bad0 < 0 && (tmr_irq[0] != exp_irq(k, eff(d0)) ||
                tmr_out[0] != exp_out(k, eff(d0), t0, l0))) bad0 = k;
            if (bad1 < 0 && (tmr_irq[1] != exp_irq(k, eff(d1)) ||
                tmr_out[1] != exp_out(k, eff(d1), t1, l1))) bad1 = k;
         end
         chk(bad0 < 0, t0 ? "R6 R2 channel 0 toggle waveform (mismatch cycle)"
                          : "R5 R7 channel 0 pulse waveform (mismatch cycle)", bad0, -1);
         chk(bad1 < 0, t1 ? "R6 R10 channel 1 toggle waveform (mismatch cycle)"
                          : "R5 R10 channel 1 pulse waveform (mismatch cycle)", bad1, -1);
      end

      // R8: stop a toggling channel, level holds, no interrupts, fresh restart
      bus_write(2'd0, 32'd0);
      idle(3);
      bus_write(2'd2, 32'd4);
      bus_write(2'd0, 32'h38);
      idle(10);
      bus_write(2'd0, 32'h00);
      idle(2);
      begin
         logic lv = tmr_out[1];
         held = 1'b1;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tmr_irq[1] || tmr_out[1] != lv) held = 1'b0;
         end
         chk(held, "R8 stopped channel silent and level held", tmr_out[1], lv);
      end
      bus_write(2'd0, 32'h18);
      @(negedge clk);
      chk(tmr_out[1] == 1'b0, "R8 restart takes new start level", tmr_out[1], 0);
      gap = 1;
      while (!tmr_irq[1] && gap < 50) begin
         @(negedge clk);
         gap++;
      end
      chk(gap == 5, "R8 restart first interrupt cycle", gap, 5);

      // R9: count write on the same edge as a reload
      bus_write(2'd0, 32'd0);
      idle(3);
      bus_write(2'd1, 32'd5);
      bus_write(2'd0, 32'h01);
      idle(10);
      bus_write(2'd1, 32'd3);
      chk(tmr_irq[0] == 1'b1, "R9 pulse on the write edge", tmr_irq[0], 1);
      gap = 0;
      do begin
         @(negedge clk);
         gap++;
      end while (!tmr_irq[0] && gap < 50);
      chk(gap == 5, "R9 reload on write edge keeps old count", gap, 5);
      gap = 0;
      do begin
         @(negedge clk);
         gap++;
      end while (!tmr_irq[0] && gap < 50);
      chk(gap == 3, "R9 next reload uses new count", gap, 3);

      finish_run();
   end
endmodule